// File: doc/BRIEF.md
# NAND Flash Bus Bridge

This block lets a processor drive a NAND flash part through plain loads and stores on a small parallel bus. Each bus access becomes one framed NAND cycle. The two lowest address bits pick the kind of cycle:

- a data byte,
- an address byte, with the address latch line raised,
- a command byte, with the command latch line raised.

Software therefore issues command, address and data bytes by writing to three neighbouring locations. It never toggles the latch lines by hand.

The bridge frames every access in three phases: setup, strobe and hold. Each phase length is a whole number of system clock cycles, taken from configuration inputs when the access is accepted. Small values are raised to a floor, so the shortest access is five clocks: two of setup, one of strobe and two of hold. During the whole frame the chip enable, the latch lines and the driven write data stay steady. A read samples the flash data lines at the end of the strobe. The bridge answers each access with a one-cycle ready pulse. Write protect is held inactive, so writes are always allowed.

Top module: `nand_bus_bridge`

## Requirements
- R1: While reset is asserted and after it is released:
  - chip enable, write strobe and read strobe are high (inactive);
  - both latch lines are low;
  - ready is low;
  - the data lines are not driven.
- R2: The bus offset is decoded as follows:
  - 0 gives a data cycle (neither latch line high);
  - 1 raises the address latch line;
  - 2 raises the command latch line;
  - 3 raises neither latch line.
  
  The two latch lines are never high together.
- R3: Chip enable and the latch lines keep their values from the first setup cycle through the last hold cycle of an access.
- R4: The phase lengths of an access are:
  - setup lasts max(cfg_setup,2) cycles;
  - strobe lasts max(cfg_pulse,1) cycles;
  - hold lasts max(cfg_hold,2) cycles.
  
  The configuration is sampled when the access is accepted.
- R5: A write access:
  - pulses only the active-low write strobe;
  - drives the stored write byte on the flash data lines, with output enable high, in every cycle of the access.
- R6: A read access:
  - pulses only the active-low read strobe, and never drives the data lines;
  - returns the flash data present in the last strobe cycle on the bus read port;
  - that value is held there until the next read completes.
- R7: Ready is high for exactly one cycle: the first cycle after chip enable returns high.
- R8: A request raised while an access is in progress is ignored. No second access follows.
- R9: Write protect is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Access request, accepted when idle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Window offset, low two bits select cycle type |
| bus_wdata_i | input | DW | Write byte |
| bus_rdata_o | output | DW | Last read byte |
| bus_ready_o | output | 1 | One-cycle completion pulse |
| cfg_setup_i | input | CW | Setup length in cycles |
| cfg_pulse_i | input | CW | Strobe length in cycles |
| cfg_hold_i | input | CW | Hold length in cycles |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_wp_no | output | 1 | Write protect, active low, held high |
| nand_io_o | output | DW | Flash data out |
| nand_io_oe_o | output | 1 | Flash data output enable |
| nand_io_i | input | DW | Flash data in |

## Verification
The bench counts the setup, strobe and hold cycles of each access, with configuration values above, at and below the floors. A design that skipped the clamp, or ran one cycle long or short, would fail those counts.

For reads, the flash data is valid only during the strobe and is replaced with garbage just before and just after it. Capturing on the wrong edge would therefore return garbage. The bench also checks that the read byte survives a later write.

Two further attacks target framing:
- A stray request during a busy access must not start a second frame.
- The ready pulse must fall in the first idle cycle and last a single cycle. A design that re-armed early, or held ready for two cycles, would be reported.

// File: rtl/nbb_pkg.sv
package nbb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  typedef struct packed {
    logic cle;
    logic ale;
  } latch_sel_t;

  // offset 1 -> address latch, 2 -> command latch, 0/3 -> plain data
  function automatic latch_sel_t decode_offset(input logic [1:0] off);
    latch_sel_t s;
    s.ale = (off == 2'd1);
    s.cle = (off == 2'd2);
    return s;
  endfunction

endpackage

// File: rtl/nbb_phase_timer.sv
module nbb_phase_timer
  import nbb_pkg::*;
#(
  parameter int unsigned CW        = 4,
  parameter int unsigned MIN_SETUP = 2,
  parameter int unsigned MIN_PULSE = 1,
  parameter int unsigned MIN_HOLD  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] cfg_setup_i,
  input  logic [CW-1:0] cfg_pulse_i,
  input  logic [CW-1:0] cfg_hold_i,
  output phase_e        phase_o,
  output logic          cap_o,
  output logic          last_o
);

  localparam logic [CW-1:0] SETUP_FLOOR = CW'(MIN_SETUP);
  localparam logic [CW-1:0] PULSE_FLOOR = CW'(MIN_PULSE);
  localparam logic [CW-1:0] HOLD_FLOOR  = CW'(MIN_HOLD);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] pulse_len_q, hold_len_q;
  logic [CW-1:0] setup_eff, pulse_eff, hold_eff;

  assign setup_eff = (cfg_setup_i < SETUP_FLOOR) ? SETUP_FLOOR : cfg_setup_i;
  assign pulse_eff = (cfg_pulse_i < PULSE_FLOOR) ? PULSE_FLOOR : cfg_pulse_i;
  assign hold_eff  = (cfg_hold_i  < HOLD_FLOOR)  ? HOLD_FLOOR  : cfg_hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      pulse_len_q <= '0;
      hold_len_q  <= '0;
    end else if (phase_q == PH_IDLE) begin
      if (start_i) begin
        phase_q     <= PH_SETUP;
        cnt_q       <= setup_eff - 1'b1;
        pulse_len_q <= pulse_eff;
        hold_len_q  <= hold_eff;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      unique case (phase_q)
        PH_SETUP: begin
          phase_q <= PH_STROBE;
          cnt_q   <= pulse_len_q - 1'b1;
        end
        PH_STROBE: begin
          phase_q <= PH_HOLD;
          cnt_q   <= hold_len_q - 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign cap_o   = (phase_q == PH_STROBE) && (cnt_q == '0);
  assign last_o  = (phase_q == PH_HOLD) && (cnt_q == '0);

  // R4: a hold that starts must run at least the floor
  p_hold_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STROBE && cnt_q == '0) |=> (phase_q == PH_HOLD && cnt_q != '0));

endmodule

// File: rtl/nbb_pin_drive.sv
module nbb_pin_drive
  import nbb_pkg::*;
#(
  parameter int unsigned AW = 2,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  phase_e        phase_i,
  input  logic          cap_i,
  input  logic [DW-1:0] io_i,
  output logic          ce_n_o,
  output logic          cle_o,
  output logic          ale_o,
  output logic          we_n_o,
  output logic          re_n_o,
  output logic [DW-1:0] io_o,
  output logic          io_oe_o,
  output logic [DW-1:0] rdata_o
);

  latch_sel_t    sel_q;
  logic          wr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept_i) begin
        sel_q   <= decode_offset(addr_i[1:0]);
        wr_q    <= we_i;
        wdata_q <= wdata_i;
      end
      if (cap_i && !wr_q) rdata_q <= io_i;
    end
  end

  assign busy    = (phase_i != PH_IDLE);
  assign ce_n_o  = !busy;
  assign cle_o   = busy && sel_q.cle;
  assign ale_o   = busy && sel_q.ale;
  assign we_n_o  = !((phase_i == PH_STROBE) && wr_q);
  assign re_n_o  = !((phase_i == PH_STROBE) && !wr_q);
  assign io_oe_o = busy && wr_q;
  assign io_o    = wdata_q;
  assign rdata_o = rdata_q;

  p_latch_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  p_strobe_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_n_o && !re_n_o));
  p_no_drive_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_n_o |-> !io_oe_o);

endmodule

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge
  import nbb_pkg::*;
#(
  parameter int unsigned AW        = 2,
  parameter int unsigned DW        = 8,
  parameter int unsigned CW        = 4,
  parameter int unsigned MIN_SETUP = 2,
  parameter int unsigned MIN_PULSE = 1,
  parameter int unsigned MIN_HOLD  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          bus_ready_o,
  input  logic [CW-1:0] cfg_setup_i,
  input  logic [CW-1:0] cfg_pulse_i,
  input  logic [CW-1:0] cfg_hold_i,
  output logic          nand_ce_no,
  output logic          nand_cle_o,
  output logic          nand_ale_o,
  output logic          nand_we_no,
  output logic          nand_re_no,
  output logic          nand_wp_no,
  output logic [DW-1:0] nand_io_o,
  output logic          nand_io_oe_o,
  input  logic [DW-1:0] nand_io_i
);

  phase_e phase;
  logic   cap, last, accept, ready_q;

  assign accept = bus_req_i && (phase == PH_IDLE);

  nbb_phase_timer #(
    .CW(CW), .MIN_SETUP(MIN_SETUP), .MIN_PULSE(MIN_PULSE), .MIN_HOLD(MIN_HOLD)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .cfg_setup_i (cfg_setup_i),
    .cfg_pulse_i (cfg_pulse_i),
    .cfg_hold_i  (cfg_hold_i),
    .phase_o     (phase),
    .cap_o       (cap),
    .last_o      (last)
  );

  nbb_pin_drive #(.AW(AW), .DW(DW)) u_pins (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .phase_i  (phase),
    .cap_i    (cap),
    .io_i     (nand_io_i),
    .ce_n_o   (nand_ce_no),
    .cle_o    (nand_cle_o),
    .ale_o    (nand_ale_o),
    .we_n_o   (nand_we_no),
    .re_n_o   (nand_re_no),
    .io_o     (nand_io_o),
    .io_oe_o  (nand_io_oe_o),
    .rdata_o  (bus_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= last;
  end

  assign bus_ready_o = ready_q;
  assign nand_wp_no  = 1'b1;

  p_wp_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nand_wp_no);
  p_latch_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_ce_no && $past(!nand_ce_no)) |-> ($stable(nand_cle_o) && $stable(nand_ale_o)));
  p_ready_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ready_o |=> !bus_ready_o);
  p_ready_after_ce_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ready_o |-> (nand_ce_no && $past(!nand_ce_no)));
  p_setup_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(nand_we_no) || $fell(nand_re_no)) |-> ($past(!nand_ce_no) && $past(!nand_ce_no, 2)));

endmodule

// File: tb/nand_bus_bridge_tb.sv
module nand_bus_bridge_tb;

  localparam int AW = 2, DW = 8, CW = 4;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, io_in = 8'hEE;
  logic [CW-1:0] c_setup = '0, c_pulse = '0, c_hold = '0;
  logic [DW-1:0] rdata, io_out;
  logic          ready, ce_n, cle, ale, we_n, re_n, wp_n, io_oe;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nand_bus_bridge #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .bus_ready_o(ready), .cfg_setup_i(c_setup), .cfg_pulse_i(c_pulse),
    .cfg_hold_i(c_hold), .nand_ce_no(ce_n), .nand_cle_o(cle),
    .nand_ale_o(ale), .nand_we_no(we_n), .nand_re_no(re_n),
    .nand_wp_no(wp_n), .nand_io_o(io_out), .nand_io_oe_o(io_oe),
    .nand_io_i(io_in)
  );

  task automatic chk(input string req_tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  function automatic int clampv(input int v, input int lo);
    return (v < lo) ? lo : v;
  endfunction

  // one full access, measured at negedges; stray=1 raises a request mid-access
  task automatic run_access(input bit w, input logic [1:0] off, input logic [7:0] d,
                            input int cs, input int cp, input int ch,
                            input logic [7:0] flash_byte, input bit stray);
    int s = 0, p = 0, h = 0, n = 0;
    bit cle_bad = 0, wrong_strobe = 0, io_bad = 0, got_ready = 0;
    bit exp_cle = (off == 2'd2), exp_ale = (off == 2'd1);
    @(negedge clk);
    c_setup = CW'(cs); c_pulse = CW'(cp); c_hold = CW'(ch);
    req = 1'b1; we = w; addr = off; wdata = d; io_in = 8'hEE;
    @(negedge clk);
    req = 1'b0;
    while (n < 100) begin
      n++;
      if (ce_n) begin
        got_ready = ready;
        break;
      end
      if (cle != exp_cle || ale != exp_ale) cle_bad = 1;
      if (w && (!io_oe || io_out != d)) io_bad = 1;
      if (!w && io_oe) io_bad = 1;
      if (!we_n || !re_n) begin
        p++;
        if (w ? !re_n : !we_n) wrong_strobe = 1;
      end else if (p == 0) s++;
      else h++;
      // flash data valid only while read strobe is low
      io_in = (!re_n) ? flash_byte : 8'hEE;
      if (stray && s == 1 && p == 0) begin
        req = 1'b1; addr = 2'd2; we = 1'b1;
      end else req = 1'b0;
      @(negedge clk);
    end
    io_in = 8'hEE;
    chk("R4 setup cycles", s, clampv(cs, 2));
    chk("R4 strobe cycles", p, clampv(cp, 1));
    chk("R4 hold cycles", h, clampv(ch, 2));
    chk("R2/R3 latch lines", cle_bad, 0);
    chk(w ? "R5 strobe select" : "R6 strobe select", wrong_strobe, 0);
    chk(w ? "R5 io drive" : "R6 io not driven", io_bad, 0);
    chk("R7 ready first idle cycle", got_ready, 1);
    chk("R9 wp high", wp_n, 1);
    @(negedge clk);
    chk("R7 ready single cycle", ready, 0);
    if (!w) chk("R6 read data", rdata, flash_byte);
  endtask

  task automatic t_reset();
    chk("R1 ce_n", ce_n, 1); chk("R1 we_n", we_n, 1); chk("R1 re_n", re_n, 1);
    chk("R1 cle", cle, 0);   chk("R1 ale", ale, 0);   chk("R1 ready", ready, 0);
    chk("R1 io_oe", io_oe, 0);
  endtask

  task automatic t_command_min();  run_access(1, 2'd2, 8'h70, 0, 0, 0, 8'h00, 0); endtask
  task automatic t_address_slow(); run_access(1, 2'd1, 8'h3C, 3, 4, 5, 8'h00, 0); endtask
  task automatic t_data_write();   run_access(1, 2'd0, 8'hA5, 2, 1, 2, 8'h00, 0); endtask
  task automatic t_offset3();      run_access(1, 2'd3, 8'h11, 1, 0, 1, 8'h00, 0); endtask

  task automatic t_read_hold();
    run_access(0, 2'd0, 8'h00, 2, 3, 2, 8'h5A, 0);
    run_access(1, 2'd0, 8'hC3, 0, 0, 0, 8'h00, 0);
    chk("R6 read data held across write", rdata, 8'h5A);
    run_access(0, 2'd0, 8'h00, 4, 1, 3, 8'h96, 0);
  endtask

  task automatic t_busy_ignored();
    int extra = 0;
    run_access(1, 2'd0, 8'h42, 3, 2, 2, 8'h00, 1);
    for (int i = 0; i < 6; i++) begin
      if (!ce_n) extra++;
      @(negedge clk);
    end
    chk("R8 request while busy ignored", extra, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_command_min();
    t_address_slow();
    t_data_write();
    t_offset3();
    t_read_hold();
    t_busy_ignored();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule